// File: doc/BRIEF.md
# Rotary Encoder Channel Selector

This block is the front-panel controller that chooses one of five audio sources. The sources are four analog-to-digital inputs and one S/PDIF input. The operator uses a quadrature rotary encoder that has a built-in push switch. The encoder phases and the switch are first synchronised to the system clock. They are then polled at a slow rate, so that contact bounce settles between two samples. The block acts only when one poll differs from the previous poll.

Editing takes two presses. The first press enters set mode and copies the live channel into a candidate. While set mode is active, rotation moves only the candidate. The second press commits the candidate as the live channel and leaves set mode. The live source therefore never changes while the knob is turning.

There are three outputs. The active channel index drives the audio multiplexer. The displayed channel index and the set-mode flag drive the display logic.

Top module: `chan_selector`

## Requirements
- R1: After reset the active channel is 0, the displayed channel is 0 and set mode is off.
- R2: The inputs pass through a two-flop synchroniser. They are then sampled once every POLL_CYCLES clocks, and only a difference between two consecutive samples produces an event. A level held only between two sample points is never seen.
- R3: A press is a switch sample of 1 (pressed) that follows a sample of 0 (released). Holding the switch down produces no further press, and releasing it produces no event.
- R4: A press while idle enters set mode and loads the candidate with the active channel.
- R5: In set mode, a clockwise step increments the candidate and wraps from 4 to 0. The phase pair {a,b} steps clockwise along 00, 01, 11, 10 and back to 00.
- R6: In set mode, a counter-clockwise step (the reverse of that sequence) decrements the candidate and wraps from 0 to 4.
- R7: Rotation while idle has no effect. Outside set mode the displayed channel equals the active channel.
- R8: A press in set mode copies the candidate into the active channel and leaves set mode. The active channel changes at no other time.
- R9: Rotation in set mode never changes the active channel.
- R10: A sample in which both phases change relative to the previous sample is not a valid step and is ignored.
- R11: When a press and a rotation step fall in the same sample, the press is acted on and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase a, asynchronous |
| enc_b_i | input | 1 | Encoder phase b, asynchronous |
| btn_i | input | 1 | Push switch, 1 = pressed, asynchronous |
| act_chan_o | output | $clog2(NUM_CHAN) | Committed source index |
| disp_chan_o | output | $clog2(NUM_CHAN) | Index to display: the candidate in set mode, otherwise the active channel |
| set_mode_o | output | 1 | High while a candidate is being edited |

## Verification
A press and a rotation step can arrive in the same poll sample. This can happen both when entering set mode and when committing. The bench provokes it by changing the switch and the encoder phase on the same clock, so both changes travel through the synchroniser together and land in one sample. The result is judged by two things. First, the mode must toggle. Second, the candidate or the committed channel must keep its value from before the step, with the step discarded. A behavioural reference model, compared every clock, covers the moment at which each output changes.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;
  typedef struct packed {
    logic a;
    logic b;
    logic btn;
  } ui_s;

  typedef enum logic {
    MODE_IDLE = 1'b0,
    MODE_SET  = 1'b1
  } mode_e;
endpackage

// File: rtl/ui_sync.sv
module ui_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], d_i[i]};
    end
    assign q_o[i] = ff_q[1];
  end
endmodule

// File: rtl/ui_poller.sv
module ui_poller
  import chan_sel_pkg::*;
#(
  parameter int POLL_CYCLES = 196608
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  ui_s  din_i,
  output ui_s  cur_o,
  output ui_s  prv_o,
  output logic vld_o
);
  localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POLL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  ui_s              cur_q, prv_q;
  logic             vld_q;

  assign tick = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  // prv holds the previous poll so each poll is compared with the one before it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      prv_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= tick;
      if (tick) begin
        cur_q <= din_i;
        prv_q <= cur_q;
      end
    end
  end

  assign cur_o = cur_q;
  assign prv_o = prv_q;
  assign vld_o = vld_q;

  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cur_q)); // R2

  if (POLL_CYCLES > 1) begin : g_pulse_chk
    AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q |=> !vld_q); // R2
  end
endmodule

// File: rtl/ui_decode.sv
module ui_decode
  import chan_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ui_s  cur_i,
  input  ui_s  prv_i,
  input  logic vld_i,
  output logic press_o,
  output logic up_o,
  output logic dn_o
);
  logic cw, ccw, press_raw;

  always_comb begin
    cw  = 1'b0;
    ccw = 1'b0;
    unique case ({prv_i.a, prv_i.b, cur_i.a, cur_i.b})
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: cw  = 1'b1;
      4'b01_00, 4'b11_01, 4'b10_11, 4'b00_10: ccw = 1'b1;
      default: ;
    endcase
  end

  assign press_raw = !prv_i.btn && cur_i.btn;
  assign press_o   = vld_i && press_raw;
  // press wins: a step in the same sample is dropped
  assign up_o      = vld_i && cw  && !press_raw;
  assign dn_o      = vld_i && ccw && !press_raw;

  AST_NO_STEP_ON_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i.a != prv_i.a) && (cur_i.b != prv_i.b) |-> !(up_o || dn_o)); // R10

  AST_HOLD_NO_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prv_i.btn |-> !press_o); // R3
endmodule

// File: rtl/ui_sel_fsm.sv
module ui_sel_fsm
  import chan_sel_pkg::*;
#(
  parameter int NUM_CHAN = 5,
  parameter int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              press_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [CHAN_W-1:0] act_o,
  output logic [CHAN_W-1:0] disp_o,
  output logic              set_o
);
  localparam logic [CHAN_W-1:0] CH_LAST = CHAN_W'(NUM_CHAN - 1);

  mode_e             mode_q;
  logic [CHAN_W-1:0] act_q, cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      act_q  <= '0;
      cand_q <= '0;
    end else if (press_i) begin
      if (mode_q == MODE_IDLE) begin
        mode_q <= MODE_SET;
        cand_q <= act_q;
      end else begin
        mode_q <= MODE_IDLE;
        act_q  <= cand_q;
      end
    end else if (mode_q == MODE_SET) begin
      if (up_i)      cand_q <= (cand_q == CH_LAST) ? '0 : cand_q + 1'b1;
      else if (dn_i) cand_q <= (cand_q == '0) ? CH_LAST : cand_q - 1'b1;
    end
  end

  assign set_o  = (mode_q == MODE_SET);
  assign act_o  = act_q;
  assign disp_o = set_o ? cand_q : act_q;

  AST_ACT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press_i |=> $stable(act_q)); // R8

  AST_ENTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(set_o) |-> cand_q == act_q); // R4

  AST_CHAN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q <= CH_LAST && cand_q <= CH_LAST); // R5

  AST_IDLE_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_o && !press_i) |=> $stable(cand_q)); // R7
endmodule

// File: rtl/chan_selector.sv
module chan_selector
  import chan_sel_pkg::*;
#(
  parameter int POLL_CYCLES = 196608,
  parameter int NUM_CHAN    = 5,
  localparam int CHAN_W     = $clog2(NUM_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              btn_i,
  output logic [CHAN_W-1:0] act_chan_o,
  output logic [CHAN_W-1:0] disp_chan_o,
  output logic              set_mode_o
);
  localparam int UI_W = $bits(ui_s);

  logic [UI_W-1:0] raw, synced;
  ui_s             cur, prv;
  logic            vld, press, up, dn;

  assign raw = {enc_a_i, enc_b_i, btn_i};

  ui_sync #(.W(UI_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  ui_poller #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (ui_s'(synced)),
    .cur_o (cur),
    .prv_o (prv),
    .vld_o (vld)
  );

  ui_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur),
    .prv_i  (prv),
    .vld_i  (vld),
    .press_o(press),
    .up_o   (up),
    .dn_o   (dn)
  );

  ui_sel_fsm #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .press_i(press),
    .up_i   (up),
    .dn_i   (dn),
    .act_o  (act_chan_o),
    .disp_o (disp_chan_o),
    .set_o  (set_mode_o)
  );

  AST_IDLE_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(set_mode_o) |-> disp_chan_o == act_chan_o); // R8
endmodule

// File: tb/tb_chan_selector.sv
module tb_chan_selector;
  localparam int P  = 16;
  localparam int NC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, btn = 1'b0;
  logic [2:0] act_o, disp_o;
  logic set_o;

  int n_chk = 0, n_fail = 0;
  int pos = 0;

  // reference model state
  int m_s1, m_s2, m_cnt, m_cur, m_prv, m_act, m_cand;
  bit m_vld, m_set;

  always #5 clk = ~clk;

  chan_selector #(.POLL_CYCLES(P), .NUM_CHAN(NC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b), .btn_i(btn),
    .act_chan_o(act_o), .disp_chan_o(disp_o), .set_mode_o(set_o)
  );

  function automatic int ring_pos(int ab);
    case (ab & 3)
      0: return 0;
      1: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model: word = {a,b,btn}
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cnt = 0; m_cur = 0; m_prv = 0;
      m_vld = 0; m_set = 0; m_act = 0; m_cand = 0;
    end else begin
      if (m_vld) begin
        bit pr;
        int d;
        pr = !m_prv[0] && m_cur[0];
        d  = (ring_pos(m_cur >> 1) - ring_pos(m_prv >> 1) + 4) % 4;
        if (pr) begin
          if (m_set) begin m_act = m_cand; m_set = 0; end
          else       begin m_cand = m_act; m_set = 1; end
        end else if (m_set && d == 1) m_cand = (m_cand + 1) % NC;
        else if (m_set && d == 3)     m_cand = (m_cand + NC - 1) % NC;
      end
      m_vld = (m_cnt == P - 1);
      if (m_cnt == P - 1) begin m_prv = m_cur; m_cur = m_s2; end
      m_cnt = (m_cnt + 1) % P;
      m_s2 = m_s1;
      m_s1 = {enc_a, enc_b, btn};
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(act_o) == m_act, "R8 model act", act_o, m_act);
      chk(int'(set_o) == int'(m_set), "R4 model set", set_o, m_set);
      chk(int'(disp_o) == (m_set ? m_cand : m_act), "R7 model disp", disp_o,
          m_set ? m_cand : m_act);
    end
  end

  task automatic settle();
    repeat (2 * P + 4) @(negedge clk);
  endtask

  task automatic set_phase();
    case (((pos % 4) + 4) % 4)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b01;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b10;
    endcase
  endtask

  task automatic turn(input int steps);
    pos += steps;
    set_phase();
    settle();
  endtask

  task automatic expect3(input string tag, input int a, input int d, input int s);
    chk(int'(act_o) == a, {tag, " act"}, act_o, a);
    chk(int'(disp_o) == d, {tag, " disp"}, disp_o, d);
    chk(int'(set_o) == s, {tag, " set"}, set_o, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect3("R1 reset", 0, 0, 0);

    turn(1);
    expect3("R7 idle rotate", 0, 0, 0);

    // R2: pulse lives only between sample points
    while (m_cnt != 2) @(negedge clk);
    btn = 1'b1;
    repeat (3) @(negedge clk);
    btn = 1'b0;
    settle();
    expect3("R2 glitch ignored", 0, 0, 0);

    btn = 1'b1; settle();
    expect3("R4 enter set", 0, 0, 1);
    repeat (3 * P) @(negedge clk);
    expect3("R3 hold no repeat", 0, 0, 1);
    btn = 1'b0; settle();
    expect3("R3 release no event", 0, 0, 1);

    turn(1); turn(1);
    expect3("R9 cw edit", 0, 2, 1);
    turn(1); turn(1); turn(1);
    expect3("R5 wrap 4 to 0", 0, 0, 1);
    turn(-1);
    expect3("R6 wrap 0 to 4", 0, 4, 1);
    turn(2);
    expect3("R10 double change", 0, 4, 1);

    btn = 1'b1; settle();
    expect3("R8 commit", 4, 4, 0);
    btn = 1'b0; settle();

    btn = 1'b1; turn(1);
    expect3("R11 press+cw enter", 4, 4, 1);
    btn = 1'b0; settle();
    turn(-1);
    expect3("R6 ccw edit", 4, 3, 1);
    btn = 1'b1; turn(-1);
    expect3("R11 press+ccw commit", 3, 3, 0);
    btn = 1'b0; settle();
    turn(1);
    expect3("R7 idle after commit", 3, 3, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule